// File: doc/BRIEF.md
# Configuration Port Transfer Controller

This block connects a simple single-cycle register bus to a 32-bit device configuration port made of a chip enable, a write enable, a data-out bus toward the port and a data-in bus from it. Software pushes configuration words into a 16-entry write queue and starts a write transfer. The engine then streams the queued words onto the port, one per cycle, until the queue is empty. For read-back, software programs a word count and starts a read transfer. The engine issues that many port reads and collects the returned words in a 16-entry read queue. It stops early if that queue fills.

Software starts a transfer with a command write. The command bit stays set while the transfer runs and is cleared by hardware when the transfer ends. Any further start command is dropped until then. A status bit reports only whether the engine is moving data. A single interrupt line combines four queue-level conditions, each behind its own enable bit.

A command can interrupt a running transfer. The engine then toggles the write enable while holding the chip enable high, which is the abort signature on the port. An independent monitor watches the port pins for that signature. It records the four 4-bit status values the port returns on data bits 7:4 in the following four cycles, raises an abort flag, and ends the transfer.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset the command register reads 0, the interrupt enables read 0, the status register reads 0x00000001, `irq` is low and `cp_ce` is low.
- R2: The interrupt enable register sits at word address 5. Its bits 3:0 hold the enables (bit 3 read-queue full, bit 2 write-queue empty, bit 1 read queue above 8 entries, bit 0 write queue below 8 entries). Writing 1 sets an enable and writing 0 clears it. Bits 31:4 always read 0.
- R3: `irq` is high exactly when some enabled source's condition holds. It follows the enables and the queue levels in the same cycle, with no extra register stage.
- R4: A bus write to word address 0 appends the data word to the 16-entry write queue. The write is dropped when the queue already holds 16 words.
- R5: Writing exactly 0x00000001 to the command register (word address 2) while idle sets command bit 0. From the next clock edge on, each edge puts the oldest queued word on `cp_din` with `cp_ce` and `cp_we` high. At the first edge that finds the queue empty, `cp_ce` falls and command bit 0 clears. For N words, `cp_ce` is high after edges 1..N and bit 0 clears at edge N+1.
- R6: Writing exactly 0x00000002 to the command register while idle sets command bit 1 and starts a read transfer. The transfer issues port reads with `cp_ce` high and `cp_we` low, starting at the next edge. It captures `cp_dout` one cycle after each issue and stops after the count held in the size register (word address 4, bits 7:0) has been read.
- R7: A read transfer issues no read that would overfill the read queue, so a count above 16 ends with exactly 16 words queued and 16 port reads issued.
- R8: While either command bit is set, start commands are ignored. A command value other than 0x1, 0x2 or (while busy) 0x4 has no effect. At most one command bit is ever set.
- R9: Status bit 0 is 1 exactly when no transfer is in progress, and `cp_ce` is low whenever it is 1.
- R10: An abort is the port write enable changing while chip enable stays high. After it, the values on `cp_dout[7:4]` in the detection cycle and the three cycles after it are stored in status bits 19:16, 23:20, 27:24 and 31:28 in that order.
- R11: Writing 0x00000004 to the command register during a transfer forces the abort signature. Once the status values are captured, status bit 1 (abort flag) is set, the command bits clear and `cp_ce` falls. The flag clears when the next transfer is started.
- R12: A read of word address 1 returns the oldest read-queue word and removes it. An empty queue returns 0 and is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe (pops the read queue at address 1) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Combined queue-level interrupt |
| cp_ce | output | 1 | Configuration port chip enable |
| cp_we | output | 1 | Configuration port write enable (1 = write) |
| cp_din | output | 32 | Word driven into the configuration port |
| cp_dout | input | 32 | Word returned by the configuration port |

## Verification
Register writes and command bits take effect at the clock edge that samples the strobe. The interrupt line and register read data follow one combinational step later, so the bench samples them at the falling edge right after that edge. In a write transfer, the first word appears one edge after the command and the last of N words after edge N. The command bit clears at edge N+1, and the bench samples each of these cycles in turn. Read transfers capture each word one edge after its issue. Abort capture spans the flip edge plus four sampling edges before the engine returns to idle, so the bench polls the idle bit for these two multi-cycle results and then checks the stored values.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int CP_DATA_W     = 32;
    localparam int CP_FIFO_DEPTH = 16;
    localparam int CP_SIZE_W     = 8;
    localparam int CP_ADDR_W     = 3;
    localparam int CP_ABT_STEPS  = 4;
    localparam int CP_NIB_W      = 4;

    typedef enum logic [CP_ADDR_W-1:0] {
        REG_WDATA = 3'd0,
        REG_RDATA = 3'd1,
        REG_CTRL  = 3'd2,
        REG_STAT  = 3'd3,
        REG_SIZE  = 3'd4,
        REG_IER   = 3'd5
    } reg_addr_e;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_WRITE,
        ENG_READ,
        ENG_ABT_FLIP,
        ENG_ABT_WAIT
    } eng_state_e;

    typedef struct packed {
        logic rf_full;
        logic wf_empty;
        logic rf_over_half;
        logic wf_under_half;
    } irq_src_t;

    typedef struct packed {
        logic                 ce;
        logic                 we;
        logic [CP_DATA_W-1:0] din;
    } port_drive_t;

    localparam logic [CP_DATA_W-1:0] CMD_CFG      = 32'h0000_0001;
    localparam logic [CP_DATA_W-1:0] CMD_READBACK = 32'h0000_0002;
    localparam logic [CP_DATA_W-1:0] CMD_ABORT    = 32'h0000_0004;

    function automatic logic irq_reduce(input logic [3:0] en, input irq_src_t src);
        return |(en & src);
    endfunction

endpackage

// File: rtl/cfgport_fifo.sv
module cfgport_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [WIDTH-1:0]             wdata,
    input  logic                         pop,
    output logic [WIDTH-1:0]             rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign count   = cnt_q;
    assign rdata   = mem[rp_q];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp_q] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wp_q <= bump(wp_q);
            end
            if (do_pop) begin
                rp_q <= bump(rp_q);
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/cfgport_abort_mon.sv
module cfgport_abort_mon
    import cfgport_pkg::*;
#(
    parameter int STEPS = CP_ABT_STEPS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cp_ce,
    input  logic                        cp_we,
    input  logic [CP_NIB_W-1:0]         port_nib,
    input  logic                        clr_flag,
    output logic                        abort_done,
    output logic                        abort_flag,
    output logic [STEPS*CP_NIB_W-1:0]   abort_stat
);
    localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

    logic                      prev_ce_q, prev_we_q;
    logic                      active_q;
    logic [SW-1:0]             step_q;
    logic                      done_q, flag_q;
    logic [STEPS*CP_NIB_W-1:0] stat_q;
    logic                      detect;

    assign detect     = cp_ce && prev_ce_q && (cp_we != prev_we_q) && !active_q;
    assign abort_done = done_q;
    assign abort_flag = flag_q;
    assign abort_stat = stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ce_q <= 1'b0;
            prev_we_q <= 1'b0;
            active_q  <= 1'b0;
            step_q    <= '0;
            done_q    <= 1'b0;
            flag_q    <= 1'b0;
            stat_q    <= '0;
        end else begin
            prev_ce_q <= cp_ce;
            prev_we_q <= cp_we;
            done_q    <= 1'b0;
            if (clr_flag) begin
                flag_q <= 1'b0;
            end
            if (detect) begin
                stat_q              <= '0;
                stat_q[CP_NIB_W-1:0] <= port_nib;
                step_q              <= SW'(1);
                active_q            <= 1'b1;
            end else if (active_q) begin
                stat_q[step_q*CP_NIB_W +: CP_NIB_W] <= port_nib;
                if (step_q == LAST) begin
                    active_q <= 1'b0;
                    step_q   <= '0;
                    done_q   <= 1'b1;
                    flag_q   <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfgport_engine.sv
module cfgport_engine
    import cfgport_pkg::*;
#(
    parameter int DEPTH  = CP_FIFO_DEPTH,
    parameter int SIZE_W = CP_SIZE_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_wr,
    input  logic                          start_rd,
    input  logic                          abort_req,
    input  logic [SIZE_W-1:0]             size,
    input  logic                          wf_empty,
    input  logic [CP_DATA_W-1:0]          wf_head,
    output logic                          wf_pop,
    input  logic [$clog2(DEPTH+1)-1:0]    rf_cnt,
    output logic                          rf_push,
    output logic [CP_DATA_W-1:0]          rf_wdata,
    input  logic [CP_DATA_W-1:0]          cp_dout,
    input  logic                          abort_done,
    output logic                          cp_ce,
    output logic                          cp_we,
    output logic [CP_DATA_W-1:0]          cp_din,
    output logic                          busy,
    output logic                          fin
);
    eng_state_e         state_q;
    port_drive_t        drv_q;
    logic [SIZE_W-1:0]  issued_q, size_q;
    logic               rd_q;
    logic               abort_go, issue_ok;

    assign cp_ce    = drv_q.ce;
    assign cp_we    = drv_q.we;
    assign cp_din   = drv_q.din;
    assign busy     = (state_q != ENG_IDLE);
    assign rf_push  = rd_q;
    assign rf_wdata = cp_dout;

    always_comb begin
        abort_go = abort_req && (state_q == ENG_WRITE || state_q == ENG_READ);
        issue_ok = (state_q == ENG_READ) && !abort_go && (issued_q != size_q)
                   && ((int'(rf_cnt) + int'(rd_q)) < DEPTH);
        wf_pop   = (state_q == ENG_WRITE) && !wf_empty && !abort_go;
        fin      = 1'b0;
        case (state_q)
            ENG_WRITE:    fin = wf_empty && !abort_go;
            ENG_READ:     fin = !issue_ok && !rd_q && !abort_go;
            ENG_ABT_WAIT: fin = abort_done;
            default:      fin = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ENG_IDLE;
            drv_q    <= '0;
            issued_q <= '0;
            size_q   <= '0;
            rd_q     <= 1'b0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    drv_q.ce <= 1'b0;
                    rd_q     <= 1'b0;
                    if (start_wr) begin
                        state_q <= ENG_WRITE;
                    end else if (start_rd) begin
                        state_q  <= ENG_READ;
                        issued_q <= '0;
                        size_q   <= size;
                    end
                end
                ENG_WRITE: begin
                    if (abort_go) begin
                        drv_q.ce <= 1'b1;
                        state_q  <= ENG_ABT_FLIP;
                    end else if (wf_empty) begin
                        drv_q.ce <= 1'b0;
                        state_q  <= ENG_IDLE;
                    end else begin
                        drv_q.ce  <= 1'b1;
                        drv_q.we  <= 1'b1;
                        drv_q.din <= wf_head;
                    end
                end
                ENG_READ: begin
                    rd_q <= 1'b0;
                    if (abort_go) begin
                        drv_q.ce <= 1'b1;
                        state_q  <= ENG_ABT_FLIP;
                    end else if (issue_ok) begin
                        drv_q.ce <= 1'b1;
                        drv_q.we <= 1'b0;
                        issued_q <= issued_q + 1'b1;
                        rd_q     <= 1'b1;
                    end else begin
                        drv_q.ce <= 1'b0;
                        if (!rd_q) begin
                            state_q <= ENG_IDLE;
                        end
                    end
                end
                ENG_ABT_FLIP: begin
                    drv_q.ce <= 1'b1;
                    drv_q.we <= ~drv_q.we;
                    state_q  <= ENG_ABT_WAIT;
                end
                ENG_ABT_WAIT: begin
                    if (abort_done) begin
                        drv_q.ce <= 1'b0;
                        state_q  <= ENG_IDLE;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
    import cfgport_pkg::*;
#(
    parameter int FIFO_DEPTH = CP_FIFO_DEPTH,
    parameter int SIZE_W     = CP_SIZE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CP_ADDR_W-1:0]  reg_addr,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [CP_DATA_W-1:0]  reg_wdata,
    output logic [CP_DATA_W-1:0]  reg_rdata,
    output logic                  irq,
    output logic                  cp_ce,
    output logic                  cp_we,
    output logic [CP_DATA_W-1:0]  cp_din,
    input  logic [CP_DATA_W-1:0]  cp_dout
);
    localparam int CW     = $clog2(FIFO_DEPTH + 1);
    localparam int HALF   = FIFO_DEPTH / 2;
    localparam int STAT_W = CP_ABT_STEPS * CP_NIB_W;

    logic                 wf_push, wf_pop, wf_full, wf_empty;
    logic [CW-1:0]        wf_cnt;
    logic [CP_DATA_W-1:0] wf_head;
    logic                 rf_push, rf_pop, rf_full, rf_empty;
    logic [CW-1:0]        rf_cnt;
    logic [CP_DATA_W-1:0] rf_head, rf_wdata;

    logic [1:0]           ctrl_q;
    logic [3:0]           ier_q;
    logic [SIZE_W-1:0]    size_q;
    logic                 busy, fin;
    logic                 wr_ctrl, start_wr, start_rd, abort_req;
    logic                 abort_done, abort_flag;
    logic [STAT_W-1:0]    abort_stat;
    irq_src_t             src;

    assign wr_ctrl   = reg_wr && (reg_addr == REG_CTRL);
    assign start_wr  = wr_ctrl && (reg_wdata == CMD_CFG)      && !busy && (ctrl_q == 2'b00);
    assign start_rd  = wr_ctrl && (reg_wdata == CMD_READBACK) && !busy && (ctrl_q == 2'b00);
    assign abort_req = wr_ctrl && (reg_wdata == CMD_ABORT);
    assign wf_push   = reg_wr && (reg_addr == REG_WDATA) && !wf_full;
    assign rf_pop    = reg_rd && (reg_addr == REG_RDATA) && !rf_empty;

    cfgport_fifo #(.WIDTH(CP_DATA_W), .DEPTH(FIFO_DEPTH)) u_wfifo (
        .clk   (clk),
        .rst   (rst),
        .push  (wf_push),
        .wdata (reg_wdata),
        .pop   (wf_pop),
        .rdata (wf_head),
        .count (wf_cnt),
        .full  (wf_full),
        .empty (wf_empty)
    );

    cfgport_fifo #(.WIDTH(CP_DATA_W), .DEPTH(FIFO_DEPTH)) u_rfifo (
        .clk   (clk),
        .rst   (rst),
        .push  (rf_push),
        .wdata (rf_wdata),
        .pop   (rf_pop),
        .rdata (rf_head),
        .count (rf_cnt),
        .full  (rf_full),
        .empty (rf_empty)
    );

    cfgport_engine #(.DEPTH(FIFO_DEPTH), .SIZE_W(SIZE_W)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .start_wr   (start_wr),
        .start_rd   (start_rd),
        .abort_req  (abort_req),
        .size       (size_q),
        .wf_empty   (wf_empty),
        .wf_head    (wf_head),
        .wf_pop     (wf_pop),
        .rf_cnt     (rf_cnt),
        .rf_push    (rf_push),
        .rf_wdata   (rf_wdata),
        .cp_dout    (cp_dout),
        .abort_done (abort_done),
        .cp_ce      (cp_ce),
        .cp_we      (cp_we),
        .cp_din     (cp_din),
        .busy       (busy),
        .fin        (fin)
    );

    cfgport_abort_mon #(.STEPS(CP_ABT_STEPS)) u_abort (
        .clk        (clk),
        .rst        (rst),
        .cp_ce      (cp_ce),
        .cp_we      (cp_we),
        .port_nib   (cp_dout[7:4]),
        .clr_flag   (start_wr || start_rd),
        .abort_done (abort_done),
        .abort_flag (abort_flag),
        .abort_stat (abort_stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= 2'b00;
            ier_q  <= 4'h0;
            size_q <= '0;
        end else begin
            if (start_wr) begin
                ctrl_q <= 2'b01;
            end else if (start_rd) begin
                ctrl_q <= 2'b10;
            end else if (fin) begin
                ctrl_q <= 2'b00;
            end
            if (reg_wr && reg_addr == REG_IER) begin
                ier_q <= reg_wdata[3:0];
            end
            if (reg_wr && reg_addr == REG_SIZE) begin
                size_q <= reg_wdata[SIZE_W-1:0];
            end
        end
    end

    always_comb begin
        src.rf_full       = rf_full;
        src.wf_empty      = wf_empty;
        src.rf_over_half  = (int'(rf_cnt) > HALF);
        src.wf_under_half = (int'(wf_cnt) < HALF);
        irq               = irq_reduce(ier_q, src);
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_RDATA: reg_rdata = rf_empty ? '0 : rf_head;
            REG_CTRL:  reg_rdata = {30'd0, ctrl_q};
            REG_STAT:  reg_rdata = {abort_stat, 14'd0, abort_flag, !busy};
            REG_SIZE:  reg_rdata = CP_DATA_W'(size_q);
            REG_IER:   reg_rdata = {28'd0, ier_q};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfgport_ctrl_chk.sv
module cfgport_ctrl_chk
    import cfgport_pkg::*;
#(
    parameter int DEPTH = CP_FIFO_DEPTH
) (
    input logic                       clk,
    input logic                       rst,
    input logic [1:0]                 ctrl,
    input logic [3:0]                 ier,
    input logic                       irq,
    input logic                       cp_ce,
    input logic                       busy,
    input logic                       abort_done,
    input logic [$clog2(DEPTH+1)-1:0] wf_cnt,
    input logic [$clog2(DEPTH+1)-1:0] rf_cnt
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl == 2'b00 && ier == 4'h0 && !cp_ce));

    assert_irq_masked_R3: assert property (@(posedge clk) disable iff (rst)
        (ier == 4'h0) |-> !irq);

    assert_wf_bound_R4: assert property (@(posedge clk) disable iff (rst)
        int'(wf_cnt) <= DEPTH);

    assert_rf_bound_R7: assert property (@(posedge clk) disable iff (rst)
        int'(rf_cnt) <= DEPTH);

    assert_one_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctrl));

    assert_idle_port_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cp_ce);

    assert_abort_ends_R11: assert property (@(posedge clk) disable iff (rst)
        abort_done |=> (ctrl == 2'b00));
endmodule

bind cfgport_ctrl cfgport_ctrl_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl_q),
    .ier        (ier_q),
    .irq        (irq),
    .cp_ce      (cp_ce),
    .busy       (busy),
    .abort_done (abort_done),
    .wf_cnt     (wf_cnt),
    .rf_cnt     (rf_cnt)
);

// File: tb/cfgport_ctrl_tb.sv
`timescale 1ns/1ps
module cfgport_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        cp_ce, cp_we;
    logic [31:0] cp_din;
    logic [31:0] cp_dout;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cfgport_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .cp_ce(cp_ce), .cp_we(cp_we), .cp_din(cp_din), .cp_dout(cp_dout)
    );

    // Port model: records writes, serves read-back words, answers the abort signature
    logic [31:0] wcap [64];
    int          wcnt = 0;
    int          rd_idx = 0;
    int          abt_seen = 0;
    logic        m_prev_ce = 1'b0, m_prev_we = 1'b0;
    int          m_step = 0;
    logic        m_det;
    localparam logic [3:0] NIB [4] = '{4'hA, 4'h5, 4'hC, 4'h3};

    assign m_det = cp_ce && m_prev_ce && (cp_we != m_prev_we) && (m_step == 0);

    always_comb begin
        cp_dout = 32'hC0DE_0000 + {16'h0, rd_idx[15:0]};
        if (m_det)
            cp_dout = 32'hFFFF_FF0F | ({28'h0, NIB[0]} << 4);
        else if (m_step >= 1 && m_step <= 3)
            cp_dout = 32'hFFFF_FF0F | ({28'h0, NIB[m_step]} << 4);
    end

    always @(posedge clk) begin
        m_prev_ce <= cp_ce;
        m_prev_we <= cp_we;
        if (m_det) begin
            m_step   <= 1;
            abt_seen <= abt_seen + 1;
        end else if (m_step >= 1 && m_step < 3) m_step <= m_step + 1;
        else m_step <= 0;
        if (cp_ce && cp_we && wcnt < 64) begin
            wcap[wcnt] <= cp_din;
            wcnt <= wcnt + 1;
        end
        if (cp_ce && !cp_we) rd_idx <= rd_idx + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            peek(3'd3, s);
            if (s[0]) break;
        end
    endtask

    // addr, write data, expected readback, expected irq (both queues empty)
    localparam logic [67:0] VEC [9] = '{
        {3'd5, 32'h0000_0000, 32'h0000_0000, 1'b0},
        {3'd5, 32'h0000_0001, 32'h0000_0001, 1'b1},
        {3'd5, 32'h0000_0002, 32'h0000_0002, 1'b0},
        {3'd5, 32'h0000_0004, 32'h0000_0004, 1'b1},
        {3'd5, 32'h0000_0008, 32'h0000_0008, 1'b0},
        {3'd5, 32'hFFFF_FFFA, 32'h0000_000A, 1'b0},
        {3'd5, 32'hFFFF_FFFF, 32'h0000_000F, 1'b1},
        {3'd5, 32'h0000_0000, 32'h0000_0000, 1'b0},
        {3'd4, 32'h0000_0123, 32'h0000_0023, 1'b0}
    };

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        peek(3'd2, d); chk("R1 ctrl", d, 32'h0);
        peek(3'd5, d); chk("R1 ier", d, 32'h0);
        peek(3'd3, d); chk("R1 status", d, 32'h1);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        chk("R1 ce", {31'd0, cp_ce}, 32'h0);

        // R2 / R3 table walk
        for (int i = 0; i < 9; i++) begin
            wr(VEC[i][67:65], VEC[i][64:33]);
            chk("R3 irq vs enables", {31'd0, irq}, {31'd0, VEC[i][0]});
            peek(VEC[i][67:65], d);
            chk("R2 readback", d, VEC[i][32:1]);
        end

        // R12 empty read queue
        rd(3'd1, d); chk("R12 empty pop", d, 32'h0);

        // R4 fill write queue with 17 words
        for (int k = 0; k < 17; k++) wr(3'd0, 32'h1000_0000 + k);
        wr(3'd5, 32'h1); chk("R3 wf not under half", {31'd0, irq}, 32'h0);
        wr(3'd5, 32'h4); chk("R3 wf not empty", {31'd0, irq}, 32'h0);
        wr(3'd5, 32'h0);

        // R5 exact write timing
        base = wcnt;
        wr(3'd2, 32'h1);
        peek(3'd2, d); chk("R5 ctrl set", d, 32'h1);
        peek(3'd3, d); chk("R9 busy", {31'd0, d[0]}, 32'h0);
        chk("R5 ce low at start", {31'd0, cp_ce}, 32'h0);
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            chk("R5 port word", {cp_ce, cp_we, 30'd0} ^ cp_din ^ 32'h0,
                {2'b11, 30'd0} ^ (32'h1000_0000 + k - 1));
        end
        @(negedge clk);
        chk("R5 ce drops", {31'd0, cp_ce}, 32'h0);
        peek(3'd2, d); chk("R5 ctrl cleared", d, 32'h0);
        peek(3'd3, d); chk("R9 idle", {31'd0, d[0]}, 32'h1);
        chk("R4 16 words kept", wcnt - base, 16);
        chk("R4 last word", wcap[base + 15], 32'h1000_000F);
        wr(3'd5, 32'h4); chk("R3 wf empty irq", {31'd0, irq}, 32'h1);
        wr(3'd5, 32'h0);

        // R8 ignored starts while busy
        for (int k = 0; k < 6; k++) wr(3'd0, 32'h2000_0000 + k);
        base = wcnt;
        wr(3'd2, 32'h1);
        wr(3'd2, 32'h2);
        wr(3'd2, 32'h1);
        peek(3'd2, d); chk("R8 ctrl unchanged", d, 32'h1);
        wait_idle();
        chk("R8 single transfer", wcnt - base, 6);
        wr(3'd2, 32'h3);
        peek(3'd2, d); chk("R8 bad command", d, 32'h0);
        wr(3'd2, 32'h4);
        peek(3'd3, d); chk("R8 abort when idle", d, 32'h1);

        // R6 read transfer of 5
        wr(3'd4, 32'd5);
        base = rd_idx;
        wr(3'd2, 32'h2);
        peek(3'd2, d); chk("R6 ctrl set", d, 32'h2);
        @(negedge clk);
        chk("R6 read issue", {30'd0, cp_ce, cp_we}, 32'h2);
        wait_idle();
        peek(3'd2, d); chk("R6 ctrl cleared", d, 32'h0);
        for (int k = 0; k < 5; k++) begin
            rd(3'd1, d); chk("R6 read word", d, 32'hC0DE_0000 + base + k);
        end
        rd(3'd1, d); chk("R12 drained", d, 32'h0);

        // R3 over-half and R7 early stop
        wr(3'd4, 32'd20);
        base = rd_idx;
        wr(3'd2, 32'h2);
        wait_idle();
        chk("R7 reads issued", rd_idx - base, 16);
        wr(3'd5, 32'h8); chk("R3 rf full irq", {31'd0, irq}, 32'h1);
        wr(3'd5, 32'h2); chk("R3 rf over half irq", {31'd0, irq}, 32'h1);
        for (int k = 0; k < 16; k++) begin
            rd(3'd1, d); chk("R7 queued word", d, 32'hC0DE_0000 + base + k);
        end
        chk("R3 drained irq", {31'd0, irq}, 32'h0);
        rd(3'd1, d); chk("R7 only 16", d, 32'h0);
        wr(3'd5, 32'h0);

        // R10 / R11 abort
        for (int k = 0; k < 12; k++) wr(3'd0, 32'h3000_0000 + k);
        base = abt_seen;
        wr(3'd2, 32'h1);
        wr(3'd2, 32'h4);
        wait_idle();
        chk("R10 signature seen", abt_seen - base, 1);
        peek(3'd3, d);
        chk("R10 captured status", {16'd0, d[31:16]}, 32'h0000_3C5A);
        chk("R11 abort flag", {31'd0, d[1]}, 32'h1);
        peek(3'd2, d); chk("R11 ctrl cleared", d, 32'h0);
        chk("R11 ce low", {31'd0, cp_ce}, 32'h0);
        wr(3'd2, 32'h1);
        peek(3'd3, d); chk("R11 flag cleared", {31'd0, d[1]}, 32'h0);
        wait_idle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule